// File: doc/BRIEF.md
# LIN Node Power and Transmit Mode Controller

This block is the digital sequencer of a LIN physical-layer node. It decides when the supply regulator is enabled and when the bus driver may pull the line dominant. It reacts to the host's chip-select/wake pin, to activity on the received bus line, and to flags from the analog side: battery good, regulator stable, overload (thermal, bus or regulator) and regulator undervoltage. The analog functions are outside the block. They appear here only as single-bit flags.

At power-on the controller samples the chip-select level and enters one of two bus-off ready modes. Edges on chip-select then walk it into transmit operation and from there into a low-power sleep. Either a falling bus edge or a chip-select rising edge wakes it from sleep. In the ready and operating modes, chip-select edges are only honoured after the regulator has been stable for a programmable number of cycles. This keeps a host that is still coming out of reset from disturbing the bus.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `mode_o` is 0 (power-on), and `reg_en_o` and `tx_en_o` are 0.
- R2: In power-on (mode 0) both enables are 0 and the mode holds while `bat_good_i` is 0. With `bat_good_i` at 1, the next mode is Ready (1) if the synchronized chip-select is 0, and Ready1 (2) if it is 1.
- R3: In Ready (1) and Ready1 (2), `reg_en_o` is 1 and `tx_en_o` is 0.
- R4: In Ready, a chip-select rising edge moves to Operation (3). `tx_en_o` is 1 in Operation and in no other mode.
- R5: In Ready1, a chip-select falling edge moves to Ready. A rising edge in Ready1 leaves the mode unchanged.
- R6: In Operation, a chip-select falling edge moves to Power-down (4), where both enables are 0. Power-down is entered only from Operation, so a falling edge in Ready changes nothing.
- R7: In Power-down, a falling edge of `bus_rx_i` moves to Wake (5). Wake has `reg_en_o`=1 and `tx_en_o`=0, and it moves to Ready once `reg_stable_i` is 1.
- R8: In Power-down, a chip-select rising edge moves straight to Operation, without any blanking delay.
- R9: In Ready, Ready1 and Operation, chip-select edges are ignored until `reg_en_o` and `reg_stable_i` have both been 1 for `BLANK_CYCLES` consecutive cycles. The count restarts whenever either of them drops.
- R10: `overload_i` in any mode with `reg_en_o`=1 moves to Fault (6), where both enables are 0. When `overload_i` clears, the mode becomes Ready1.
- R11: `reg_uv_i` in any mode with `reg_en_o`=1 returns to power-on (0). It takes precedence over `overload_i`.
- R12: Chip-select and bus inputs pass through two synchronizer flops. A chip-select change applied before clock edge A acts on the mode at the third rising edge, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bat_good_i | input | 1 | Battery above turn-on threshold |
| reg_stable_i | input | 1 | Regulator output settled |
| cs_wake_i | input | 1 | Chip-select/wake pin, asynchronous |
| bus_rx_i | input | 1 | Received bus level (0 = dominant), asynchronous |
| overload_i | input | 1 | Thermal, bus or regulator overload flag |
| reg_uv_i | input | 1 | Regulator output below shutdown threshold |
| reg_en_o | output | 1 | Regulator enable |
| tx_en_o | output | 1 | Bus transmitter enable |
| mode_o | output | 3 | Current mode code (0..6 as listed above) |

## Verification
The hardest case to set up is telling a blanked chip-select edge apart from an edge that is ignored because of the mode. Ready1 discards rising edges whatever the timer says, and every entry into a regulator-on mode restarts the timer. The stimulus therefore reaches Ready1 through a fault recovery with chip-select held low, waits out the blanking window, and only then raises chip-select. Blanking is exercised separately, with edges placed a few cycles after power-on and after a wake.

// File: rtl/lin_mode_pkg.sv
`timescale 1ns/1ps
package lin_mode_pkg;

  typedef enum logic [2:0] {
    M_POR    = 3'd0,
    M_READY  = 3'd1,
    M_READY1 = 3'd2,
    M_OPER   = 3'd3,
    M_PDOWN  = 3'd4,
    M_WAKE   = 3'd5,
    M_FAULT  = 3'd6
  } lin_mode_e;

  // Regulator is powered in these modes
  function automatic logic mode_reg_on(lin_mode_e m);
    return (m == M_READY) || (m == M_READY1) || (m == M_OPER) || (m == M_WAKE);
  endfunction

  // Bus driver may be active only here
  function automatic logic mode_tx_on(lin_mode_e m);
    return (m == M_OPER);
  endfunction

  // Chip-select edges in these modes wait for the blanking timer
  function automatic logic mode_cs_blanked(lin_mode_e m);
    return (m == M_READY) || (m == M_READY1) || (m == M_OPER);
  endfunction

  // Ready flavour chosen by the chip-select level at power-on
  function automatic lin_mode_e por_entry(logic cs_level);
    return cs_level ? M_READY1 : M_READY;
  endfunction

endpackage

// File: rtl/lin_sync2.sv
`timescale 1ns/1ps
module lin_sync2 #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/lin_edge_det.sv
`timescale 1ns/1ps
module lin_edge_det #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise[i] = lvl[i] & ~prev[i];
    assign fall[i] = ~lvl[i] & prev[i];

    // R12: an edge lasts one synchronized cycle only
    p_rise_single_r12: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]);
    p_fall_single_r12: assert property (@(posedge clk) disable iff (rst)
      fall[i] |=> !fall[i]);
  end
endmodule

// File: rtl/lin_blank_timer.sv
`timescale 1ns/1ps
module lin_blank_timer #(
  parameter int LIMIT = 30000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)                cnt <= '0;
    else if (cnt != CW'(LIMIT))     cnt <= cnt + 1'b1;
  end

  assign done = (cnt == CW'(LIMIT));

  // R9: a dropped run condition restarts the window
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    !run |=> !done);
  // R9: once saturated, stays open while run holds
  p_hold_open_r9: assert property (@(posedge clk) disable iff (rst)
    (done && run) |=> done);
endmodule

// File: rtl/lin_mode_fsm.sv
`timescale 1ns/1ps
module lin_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      bat_good,
  input  logic      reg_stable,
  input  logic      cs_lvl,
  input  logic      cs_rise,
  input  logic      cs_fall,
  input  logic      bus_fall,
  input  logic      overload,
  input  logic      reg_uv,
  input  logic      blank_done,
  output lin_mode_e state
);
  lin_mode_e nxt;
  logic      cs_ok;

  assign cs_ok = blank_done || !mode_cs_blanked(state);

  always_comb begin
    nxt = state;
    unique case (state)
      M_POR:    if (bat_good)            nxt = por_entry(cs_lvl);
      M_READY:  if (cs_rise && cs_ok)    nxt = M_OPER;
      M_READY1: if (cs_fall && cs_ok)    nxt = M_READY;
      M_OPER:   if (cs_fall && cs_ok)    nxt = M_PDOWN;
      M_PDOWN:  if (cs_rise)             nxt = M_OPER;
                else if (bus_fall)       nxt = M_WAKE;
      M_WAKE:   if (reg_stable)          nxt = M_READY;
      M_FAULT:  if (!overload)           nxt = M_READY1;
      default:                           nxt = M_POR;
    endcase
    if (mode_reg_on(state)) begin
      if (reg_uv)        nxt = M_POR;
      else if (overload) nxt = M_FAULT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= M_POR;
    else     state <= nxt;
  end

  // R9: an edge inside the blanking window leaves Ready alone
  p_blank_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (state == M_READY && cs_rise && !blank_done && !reg_uv && !overload)
      |=> state == M_READY);
  // R7: bus wake from power-down
  p_bus_wake_r7: assert property (@(posedge clk) disable iff (rst)
    (state == M_PDOWN && bus_fall && !cs_rise) |=> state == M_WAKE);
  // R8: chip-select wake needs no blanking
  p_cs_wake_r8: assert property (@(posedge clk) disable iff (rst)
    (state == M_PDOWN && cs_rise) |=> state == M_OPER);
  // R10: fault recovery always lands in Ready1
  p_fault_exit_r10: assert property (@(posedge clk) disable iff (rst)
    (state == M_FAULT && !overload) |=> state == M_READY1);
  // R11: undervoltage wins over overload
  p_uv_first_r11: assert property (@(posedge clk) disable iff (rst)
    (mode_reg_on(state) && reg_uv) |=> state == M_POR);
endmodule

// File: rtl/lin_mode_ctrl.sv
`timescale 1ns/1ps
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int BLANK_CYCLES = 30000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bat_good_i,
  input  logic       reg_stable_i,
  input  logic       cs_wake_i,
  input  logic       bus_rx_i,
  input  logic       overload_i,
  input  logic       reg_uv_i,
  output logic       reg_en_o,
  output logic       tx_en_o,
  output logic [2:0] mode_o
);
  // bit 1 = bus (idles recessive high), bit 0 = chip-select
  localparam int         NSYNC    = 2;
  localparam logic [1:0] SYNC_RST = 2'b10;

  logic [NSYNC-1:0] pins_sync, pins_rise, pins_fall;
  logic             cs_rise, cs_fall, bus_rise, bus_fall;
  logic             blank_run, blank_done;
  lin_mode_e        mode;

  lin_sync2 #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk), .rst (rst),
    .d   ({bus_rx_i, cs_wake_i}),
    .q   (pins_sync)
  );

  lin_edge_det #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_edge (
    .clk  (clk), .rst (rst),
    .lvl  (pins_sync),
    .rise (pins_rise),
    .fall (pins_fall)
  );

  assign cs_rise  = pins_rise[0];
  assign cs_fall  = pins_fall[0];
  assign bus_rise = pins_rise[1];
  assign bus_fall = pins_fall[1];

  assign blank_run = reg_en_o && reg_stable_i;

  lin_blank_timer #(.LIMIT(BLANK_CYCLES)) u_blank (
    .clk  (clk), .rst (rst),
    .run  (blank_run),
    .done (blank_done)
  );

  lin_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .bat_good   (bat_good_i),
    .reg_stable (reg_stable_i),
    .cs_lvl     (pins_sync[0]),
    .cs_rise    (cs_rise),
    .cs_fall    (cs_fall),
    .bus_fall   (bus_fall),
    .overload   (overload_i),
    .reg_uv     (reg_uv_i),
    .blank_done (blank_done),
    .state      (mode)
  );

  assign reg_en_o = mode_reg_on(mode);
  assign tx_en_o  = mode_tx_on(mode);
  assign mode_o   = mode;

  // R4: driver enabled only with the regulator up
  p_tx_needs_reg_r4: assert property (@(posedge clk) disable iff (rst)
    tx_en_o |-> reg_en_o);
  // R6: power-down reachable only from operation
  p_pdown_from_oper_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == M_PDOWN && $past(mode) != M_PDOWN) |-> $past(mode) == M_OPER);
  // R6: a rising bus level alone does not leave power-down
  p_bus_rise_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == M_PDOWN && bus_rise && !cs_rise) |=> mode == M_PDOWN);
  // R1: reset returns to power-on with everything off
  p_reset_off_r1: assert property (@(posedge clk)
    rst |=> (mode_o == 3'd0 && !reg_en_o && !tx_en_o));
endmodule

// File: tb/lin_mode_ctrl_tb.sv
`timescale 1ns/1ps
module lin_mode_ctrl_tb;
  localparam int BLANK = 16;

  logic clk = 1'b0;
  logic rst, bat, stb, cs, bus, ovl, uv;
  logic reg_en, tx_en;
  logic [2:0] mode;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  lin_mode_ctrl #(.BLANK_CYCLES(BLANK)) u_dut (
    .clk (clk), .rst (rst),
    .bat_good_i (bat), .reg_stable_i (stb), .cs_wake_i (cs),
    .bus_rx_i (bus), .overload_i (ovl), .reg_uv_i (uv),
    .reg_en_o (reg_en), .tx_en_o (tx_en), .mode_o (mode)
  );

  typedef struct packed {
    logic bat, stb, cs, bus, ovl, uv;
    logic [7:0] wt;
    logic [2:0] md;
    logic rg, tx;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 27;
  // fields: bat stb cs bus ovl uv | wait | mode reg tx | requirement
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 8'd2,  3'd0,1'b0,1'b0, 4'd2 },  // R2 no battery: hold
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'd2,  3'd1,1'b1,1'b0, 4'd2 },  // R2 cs low -> Ready, R3
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 8'd4,  3'd1,1'b1,1'b0, 4'd9 },  // R9 early rise blanked
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 8'd20, 3'd1,1'b1,1'b0, 4'd6 },  // R6 fall in Ready ignored
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 8'd4,  3'd3,1'b1,1'b1, 4'd4 },  // R4 Ready -> Operation
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 8'd4,  3'd4,1'b0,1'b0, 4'd6 },  // R6 -> Power-down
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd4,  3'd5,1'b1,1'b0, 4'd7 },  // R7 bus fall -> Wake
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'd3,  3'd1,1'b1,1'b0, 4'd7 },  // R7 stable -> Ready
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 8'd4,  3'd1,1'b1,1'b0, 4'd9 },  // R9 timer restarted
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 8'd20, 3'd1,1'b1,1'b0, 4'd9 },  // R9 settle
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 8'd4,  3'd3,1'b1,1'b1, 4'd4 },  // R4
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 8'd4,  3'd4,1'b0,1'b0, 4'd6 },  // R6
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 8'd4,  3'd3,1'b1,1'b1, 4'd8 },  // R8 direct wake
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0, 8'd3,  3'd6,1'b0,1'b0, 4'd10},  // R10 overload -> Fault
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 8'd20, 3'd2,1'b1,1'b0, 4'd10},  // R10 recover -> Ready1
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 8'd4,  3'd1,1'b1,1'b0, 4'd5 },  // R5 Ready1 fall -> Ready
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 8'd4,  3'd3,1'b1,1'b1, 4'd4 },  // R4
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 8'd3,  3'd0,1'b0,1'b0, 4'd11},  // R11 uv beats overload
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 8'd4,  3'd0,1'b0,1'b0, 4'd2 },  // R2 wait battery
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 8'd3,  3'd2,1'b1,1'b0, 4'd2 },  // R2 cs high -> Ready1, R3
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 8'd3,  3'd2,1'b1,1'b0, 4'd9 },  // R9 early fall blanked
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 8'd20, 3'd2,1'b1,1'b0, 4'd5 },  // R5
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 8'd4,  3'd1,1'b1,1'b0, 4'd5 },  // R5 fall after window
    '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0, 8'd3,  3'd6,1'b0,1'b0, 4'd10},  // R10
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 8'd20, 3'd2,1'b1,1'b0, 4'd10},  // R10 Ready1, cs low
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 8'd4,  3'd2,1'b1,1'b0, 4'd5 },  // R5 rise in Ready1 ignored
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 8'd4,  3'd1,1'b1,1'b0, 4'd5 }   // R5
  };

  task automatic check(input string tag, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic check_outs(input string tag, input int md, input int rg, input int tx);
    check({tag, " mode"},   int'(mode),   md);
    check({tag, " reg_en"}, int'(reg_en), rg);
    check({tag, " tx_en"},  int'(tx_en),  tx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; bat = 1'b0; stb = 1'b0; cs = 1'b0; bus = 1'b1; ovl = 1'b0; uv = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_outs("R1 in reset", 0, 0, 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check_outs("R1 after reset", 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      bat = VECS[i].bat; stb = VECS[i].stb; cs = VECS[i].cs;
      bus = VECS[i].bus; ovl = VECS[i].ovl; uv = VECS[i].uv;
      repeat (int'(VECS[i].wt)) @(posedge clk);
      @(negedge clk);
      check_outs($sformatf("R%0d vector %0d", VECS[i].rq, i),
                 int'(VECS[i].md), int'(VECS[i].rg), int'(VECS[i].tx));
    end

    // R12: in Ready with the window open, the rise acts on the third edge
    cs = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R12 two edges", int'(mode), 1);
    @(posedge clk); @(negedge clk);
    check("R12 third edge", int'(mode), 3);
    check("R12 tx_en", int'(tx_en), 1);

    // R1: reset from Operation
    bat = 1'b0; stb = 1'b0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check_outs("R1 reset from operation", 0, 0, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule